// File: doc/BRIEF.md
# Segmented carry-pipelined accumulator

This block keeps a running sum of a wide input word (100 bits by default) and still closes timing at the rate of a short accumulator. The sum register is cut into a small number of segments, two to four, chosen at elaboration. Each segment has its own adder. The carry out of each segment is captured in one flip-flop and enters the segment above on the following cycle, so no carry chain is longer than one segment.

Because carries lag by a cycle per boundary, the raw register contents are not a finished sum while inputs are still arriving. When the caller has presented its last term, it raises a flush request. The block then spends segment-count minus one cycles adding nothing but the pending carries. After that it raises a done flag, and the result port holds the exact sum modulo two to the width. The caller gives up a few cycles of latency at the end of each run and gains a short critical path.

Segment widths are fixed at elaboration by splitting the width as evenly as possible, with any spare bits going to the lowest segments. With the defaults this gives slices of 34, 33 and 33 bits, so the carry boundaries sit above bits 33 and 66.

Top module: `seg_accum`

## Requirements
- R1: After synchronous reset (rst_n low at a clock edge), result reads zero and done is low.
- R2: Each clock edge with en high outside a flush adds din to the sum. A flush requested in the same cycle as an enabled input includes that input. Once done rises, result equals the sum of all accepted inputs since the last clear or reset.
- R3: A clock edge with clr high zeroes every segment and every inter-segment carry flip-flop and drops done, whatever en and flush are. clr takes priority over both.
- R4: Carries that cross segment boundaries, including a carry that must travel through every boundary, appear in result by the time done is high.
- R5: If flush is sampled at an edge outside a flush phase, done stays low for the next NSEG-2 edges and is high after the (NSEG-1)th edge that follows it, where NSEG is the segment count.
- R6: The carry out of the top segment is dropped, so the sum wraps modulo 2 to the power of WIDTH.
- R7: Edges with en low, clr low and no flush in progress leave result and done unchanged.
- R8: During the flush phase, en, din and flush are ignored. Only the registered carries are added.
- R9: While done is high, an enabled input (without flush) drops done at that edge. A new flush request re-runs the flush phase and leaves the result unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, all state changes on the rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| clr | input | 1 | Synchronous clear of the sum and all carries |
| en | input | 1 | Accept din into the sum this cycle |
| din | input | WIDTH | Term to add |
| flush | input | 1 | Start the carry flush phase |
| result | output | WIDTH | Accumulated sum, exact while done is high |
| done | output | 1 | Flush completed, result valid |

## Verification
The embedded assertions check, on every cycle, several local properties. A clear empties each segment and the controller. A segment that is not stepped holds its value and its carry. A flush request from idle starts the phase counter at zero. An enabled input drops done. No inter-segment carry is pending while done is high. Whether the settled value is the true modulo sum of the accepted terms can only be shown by the bench's scenarios. The same holds for the exact done latency after a flush request, and for whether noise on en, din and flush during a flush leaves the sum untouched. Those scenarios are carries rippling across both boundaries, full wraparound, hold gaps inside a run, re-flushing and a clear that collides with other requests.

// File: rtl/seg_accum_pkg.sv
// Package: shared state encoding and segment geometry helpers for seg_accum.
// Assumes: nseg >= 1 and width >= nseg.
package seg_accum_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FLUSH = 2'd1,
        ST_DONE  = 2'd2
    } acc_state_e;

    // Width of segment idx: even split, leftover bits go to the lowest segments.
    function automatic int seg_width(input int width, input int nseg, input int idx);
        return (width / nseg) + ((idx < (width % nseg)) ? 1 : 0);
    endfunction

    // Bit position of the least significant bit of segment idx.
    function automatic int seg_base(input int width, input int nseg, input int idx);
        int base;
        base = 0;
        for (int k = 0; k < idx; k++) begin
            base += seg_width(width, nseg, k);
        end
        return base;
    endfunction

endpackage

// File: rtl/acc_segment.sv
// Module: one slice of the segmented accumulator.
// Adds its addend slice plus the carry registered by the slice below.
// When CARRY_OUT is set, it captures its own carry out in a flip-flop for the
// slice above. The top slice drops its carry, so the sum wraps.
// Assumes: clr has priority over step; rst_n is synchronous, active low.
module acc_segment #(
    parameter int SW        = 34,
    parameter bit CARRY_OUT = 1'b1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          step,
    input  logic [SW-1:0] addend,
    input  logic          cin,
    output logic [SW-1:0] acc_q,
    output logic          cout_q
);

    generate
        if (CARRY_OUT) begin : g_carry
            logic [SW:0] total;

            // Slice sum with one extra bit to expose the carry out.
            assign total = {1'b0, acc_q} + {1'b0, addend} + {{SW{1'b0}}, cin};

            // Slice register and carry flip-flop: clear, step or hold.
            always_ff @(posedge clk) begin
                if (!rst_n || clr) begin
                    acc_q  <= '0;
                    cout_q <= 1'b0;
                end else if (step) begin
                    acc_q  <= total[SW-1:0];
                    cout_q <= total[SW];
                end
            end
        end else begin : g_top
            logic [SW-1:0] total;

            // Top slice sum, carry out intentionally truncated (wraparound).
            assign total = acc_q + addend + {{(SW-1){1'b0}}, cin};

            // Top slice register: clear, step or hold.
            always_ff @(posedge clk) begin
                if (!rst_n || clr) begin
                    acc_q <= '0;
                end else if (step) begin
                    acc_q <= total;
                end
            end

            assign cout_q = 1'b0;
        end
    endgenerate

    // R3: a clear empties the slice and its carry at the next edge.
    a_r3_seg_clear: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (acc_q == '0) && !cout_q);

    // R7: an unstepped, uncleared slice holds value and carry.
    a_r7_seg_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !step) |=> $stable(acc_q) && $stable(cout_q));

endmodule

// File: rtl/flush_ctrl.sv
// Module: sequencing for the segmented accumulator.
// Tracks accumulate, flush and done phases and counts NSEG-1 flush cycles.
// It tells the slices when to step and when to force a zero addend.
// Assumes: NSEG >= 2; clr has priority over every other request.
module flush_ctrl
    import seg_accum_pkg::*;
#(
    parameter int NSEG = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic en,
    input  logic flush,
    output logic step,
    output logic zero_in,
    output logic done
);

    localparam int CW = (NSEG > 2) ? $clog2(NSEG - 1) : 1;
    localparam logic [CW-1:0] LAST = CW'(NSEG - 2);

    acc_state_e    state;
    logic [CW-1:0] cnt;

    // Phase register and flush-cycle counter.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            state <= ST_IDLE;
            cnt   <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (flush) begin
                        state <= ST_FLUSH;
                        cnt   <= '0;
                    end
                end
                ST_FLUSH: begin
                    if (cnt == LAST) begin
                        state <= ST_DONE;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_DONE: begin
                    if (flush) begin
                        state <= ST_FLUSH;
                        cnt   <= '0;
                    end else if (en) begin
                        state <= ST_IDLE;
                    end
                end
                default: begin
                    state <= ST_IDLE;
                    cnt   <= '0;
                end
            endcase
        end
    end

    // Step slices on accepted input or on every flush cycle; gate input while flushing.
    always_comb begin
        zero_in = (state == ST_FLUSH);
        step    = zero_in || en;
        done    = (state == ST_DONE);
    end

    // R3: a clear returns the controller to the accumulate phase with done low.
    a_r3_ctrl_clear: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (state == ST_IDLE) && !done);

    // R5: a flush request from the accumulate phase starts a fresh count.
    a_r5_flush_start: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && flush && !clr) |=> (state == ST_FLUSH) && (cnt == '0));

    // R9: an enabled input while done drops done.
    a_r9_done_exit: assert property (@(posedge clk) disable iff (!rst_n)
        (done && en && !flush && !clr) |=> !done);

endmodule

// File: rtl/seg_accum.sv
// Module: segmented carry-pipelined accumulator (top).
// Splits a WIDTH-bit sum into NSEG slices joined by registered carries.
// After a flush of NSEG-1 cycles it flags an exact result modulo 2^WIDTH.
// Assumes: 2 <= NSEG <= 4, WIDTH >= NSEG; rst_n synchronous, active low.
module seg_accum
    import seg_accum_pkg::*;
#(
    parameter int WIDTH = 100,
    parameter int NSEG  = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             en,
    input  logic [WIDTH-1:0] din,
    input  logic             flush,
    output logic [WIDTH-1:0] result,
    output logic             done
);

    logic             step;
    logic             zero_in;
    logic [WIDTH-1:0] addend;
    logic [NSEG-1:0]  carry_q;
    logic             carries_pending;

    flush_ctrl #(
        .NSEG (NSEG)
    ) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (clr),
        .en      (en),
        .flush   (flush),
        .step    (step),
        .zero_in (zero_in),
        .done    (done)
    );

    // Input gate: slices see zero while carries are being flushed.
    assign addend = zero_in ? '0 : din;

    generate
        for (genvar i = 0; i < NSEG; i++) begin : g_seg
            localparam int SW = seg_width(WIDTH, NSEG, i);
            localparam int LO = seg_base(WIDTH, NSEG, i);

            logic          cin_w;
            logic [SW-1:0] slice_q;

            if (i == 0) begin : g_bottom
                assign cin_w = 1'b0;
            end else begin : g_upper
                assign cin_w = carry_q[i-1];
            end

            acc_segment #(
                .SW        (SW),
                .CARRY_OUT (i < NSEG - 1)
            ) u_slice (
                .clk    (clk),
                .rst_n  (rst_n),
                .clr    (clr),
                .step   (step),
                .addend (addend[LO +: SW]),
                .cin    (cin_w),
                .acc_q  (slice_q),
                .cout_q (carry_q[i])
            );

            assign result[LO +: SW] = slice_q;
        end
    endgenerate

    // Any carry still travelling between slices.
    assign carries_pending = |carry_q;

    // R4: once done, no carry is left between slices.
    a_r4_settled: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !carries_pending);

    // R7: an idle edge outside a flush keeps done unchanged.
    a_r7_done_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !en && !flush && !zero_in) |=> (done == $past(done)));

endmodule

// File: tb/tb_seg_accum.sv
// Scoreboard bench: the driver pushes the expected sum when it requests a flush.
// A monitor pops and compares it when done rises.
module tb_seg_accum;

    localparam int W    = 100;
    localparam int N    = 3;
    localparam int HALF = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         clr = 1'b0;
    logic         en = 1'b0;
    logic         flush = 1'b0;
    logic [W-1:0] din = '0;
    logic [W-1:0] result;
    logic         done;

    int           checks = 0;
    int           errors = 0;
    bit           finished = 1'b0;
    logic [W-1:0] model = '0;
    logic [W-1:0] expq[$];
    string        tagq[$];
    logic         done_d = 1'b0;

    seg_accum #(.WIDTH(W), .NSEG(N)) dut (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (clr),
        .en     (en),
        .din    (din),
        .flush  (flush),
        .result (result),
        .done   (done)
    );

    always #HALF clk = ~clk;

    task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [W-1:0] rnd();
        logic [127:0] r;
        r = {$urandom, $urandom, $urandom, $urandom};
        return r[W-1:0];
    endfunction

    // Drive one cycle of inputs at a falling edge, return at the next falling edge.
    task automatic tick(input logic e, input logic [W-1:0] d, input logic f, input logic c);
        en = e; din = d; flush = f; clr = c;
        @(negedge clk);
        en = 1'b0; din = '0; flush = 1'b0; clr = 1'b0;
    endtask

    task automatic add(input logic [W-1:0] d);
        model = model + d;
        tick(1'b1, d, 1'b0, 1'b0);
    endtask

    // Request a flush, optionally merging a last input, and check done timing (R5).
    task automatic run_flush(input string tag, input bit noisy, input bit with_last, input logic [W-1:0] last_d);
        if (with_last) model = model + last_d;
        expq.push_back(model);
        tagq.push_back(tag);
        tick(with_last, last_d, 1'b1, 1'b0);
        for (int k = 1; k < N; k++) begin
            check("R5 done low during flush", W'(done), W'(1'b0));
            // R8: noise on en, din and flush must be ignored while flushing.
            if (noisy) tick(1'b1, rnd(), 1'b1, 1'b0);
            else       tick(1'b0, '0, 1'b0, 1'b0);
        end
        check("R5 done high after NSEG-1 flush cycles", W'(done), W'(1'b1));
    endtask

    // Monitor: compare the expected sum when done rises (R2).
    always @(negedge clk) begin
        if (rst_n && done && !done_d) begin
            if (expq.size() == 0) begin
                checks++;
                errors++;
                $display("FAIL R2 unexpected done: actual=%h expected=no result", result);
            end else begin
                check(tagq.pop_front(), result, expq.pop_front());
            end
        end
        done_d = done;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #(200000 * 2 * HALF);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL R5 watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [W-1:0] held;
        @(negedge clk);
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        check("R1 reset result", result, '0);
        check("R1 reset done", W'(done), W'(1'b0));

        // R2: basic sum, then a flush merged with a last input.
        add(W'(5));
        add(W'(7));
        run_flush("R2 small sum", 1'b0, 1'b0, '0);
        add(W'(100));
        run_flush("R2 flush with last input", 1'b0, 1'b1, W'(23));

        // R7: idle edges hold result and done.
        held = result;
        for (int k = 0; k < 3; k++) begin
            tick(1'b0, rnd(), 1'b0, 1'b0);
            check("R7 done held", W'(done), W'(1'b1));
            check("R7 result held", result, held);
        end

        // R9: re-flush while done keeps the result; an input drops done.
        run_flush("R9 reflush unchanged", 1'b0, 1'b0, '0);
        add(W'(1));
        check("R9 done drops on input", W'(done), W'(1'b0));
        run_flush("R9 after input", 1'b0, 1'b0, '0);

        // R3: clear beats en and flush.
        add(rnd());
        tick(1'b1, rnd(), 1'b1, 1'b1);
        model = '0;
        check("R3 done low after clear", W'(done), W'(1'b0));
        check("R3 result zero after clear", result, '0);
        run_flush("R3 flush after clear", 1'b0, 1'b0, '0);

        // R4: carries across the slice boundaries (34/33/33 split).
        add((W'(1) << 34) - W'(1));
        add(W'(1));
        run_flush("R4 first boundary", 1'b0, 1'b0, '0);
        add((W'(1) << 67) - (W'(1) << 34));
        run_flush("R4 second boundary", 1'b0, 1'b0, '0);
        tick(1'b0, '0, 1'b0, 1'b1);
        model = '0;
        add((W'(1) << 67) - W'(1));
        add(W'(1));
        run_flush("R4 carry through both boundaries", 1'b0, 1'b0, '0);

        // R6: wraparound modulo 2^W.
        tick(1'b0, '0, 1'b0, 1'b1);
        model = '0;
        add('1);
        add(W'(1));
        run_flush("R6 wrap to zero", 1'b0, 1'b0, '0);
        add('1);
        add('1);
        run_flush("R6 double all-ones", 1'b0, 1'b0, '0);

        // R7 and R8: gaps inside runs, noisy flush phases, random terms.
        for (int it = 0; it < 20; it++) begin
            int len;
            len = 1 + ($urandom % 6);
            for (int j = 0; j < len; j++) begin
                add(rnd());
                if (($urandom % 3) == 0) tick(1'b0, rnd(), 1'b0, 1'b0);
            end
            run_flush("R8 noisy flush random run", 1'b1, 1'b0, '0);
        end

        repeat (2) @(negedge clk);
        check("R2 all expected results seen", W'(expq.size()), '0);
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule